// File: doc/BRIEF.md
# Timebase Counter with Keyed Clear

This block is a free-running binary counter that acts as the common time reference for the slower timers around it. Those timers include an oscillator settling wait, a watchdog interval and a periodic interval timer. Each of them takes one of the block's tap strobes. A tap strobe is a single-cycle pulse that fires whenever a chosen counter bit falls from one to zero through normal counting.

Software cannot load the counter. It can only zero the counter, through a write-only, byte-wide clear location on a simple peripheral write bus. A clear takes effect only after a two-byte key has been written in order. The first byte arms a small tracker. The second byte, written at any later time, zeroes the whole counter on the clock edge that accepts it. A clear also restarts every tap period from zero. A single-cycle `clear_pulse_o` marks the cycle in which the counter shows zero after a clear. Reads of the location carry no meaning, and the block drives a constant on the read bus.

Top module: `tbt_timebase`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `count_o` is 0 and `tap_o` and `clear_pulse_o` are 0. Reset also drops an armed key, so a 0x5A written after reset does not clear the counter.
- R2: `count_o` rises by exactly one on every clock edge that has no clear, and wraps from all ones to 0 (modulo 2^CNT_W).
- R3: A write (`bus_wr`=1) of byte 0xA5 to address `REG_ADDR` (default 0x0483) arms the block. A later write of 0x5A to the same address while armed makes `count_o` read 0 in the cycle right after the edge that accepts that write.
- R4: The armed state lasts through any number of cycles with no write, so 0xA5, then N idle cycles, then 0x5A still clears the counter.
- R5: While armed, a write to `REG_ADDR` of any byte other than 0x5A or 0xA5 disarms the block. A 0x5A that follows it does not clear the counter.
- R6: A 0x5A written to `REG_ADDR` while disarmed is ignored, and the counter keeps counting.
- R7: A 0xA5 written while already armed leaves the block armed, so a following 0x5A clears the counter.
- R8: Writes to any address other than `REG_ADDR` neither arm, disarm nor clear the counter.
- R9: `clear_pulse_o` is high for exactly one cycle, the cycle in which `count_o` reads 0 because of a clear, and low at all other times. After a completed clear the block is disarmed.
- R10: For tap i at bit position P (field i of `TAP_POS`, 8 bits per field, field 0 in the least significant byte), `tap_o[i]` is high for one cycle exactly when bits P..0 of `count_o` have just become 0 by counting. A clear never raises a tap, and each tap period restarts from the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read data, constant with no meaning |
| count_o | output | CNT_W | Timebase counter value |
| tap_o | output | NTAP | Period strobes, one per tap position |
| clear_pulse_o | output | 1 | High in the cycle the counter reads 0 after a clear |

## Verification
The assertions take for granted that the bus inputs are stable around the rising edge and carry no unknown values while `bus_wr` is high. They also take for granted that every tap position lies below `CNT_W`. The stimulus drives all bus signals only on falling edges and holds `bus_wr` low between writes. It uses an 8-bit counter with taps at bits 1, 3 and 6, which runs the counter through several complete wraps. The key sequences land at arbitrary counter phases, including cycles next to tap boundaries.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
    localparam logic [7:0] KEY_ARM  = 8'hA5;
    localparam logic [7:0] KEY_FIRE = 8'h5A;
    localparam int         TAP_FW   = 8;   // width of one tap-position field

    typedef enum logic {
        UNL_IDLE  = 1'b0,
        UNL_ARMED = 1'b1
    } unl_state_e;

    typedef struct packed {
        unl_state_e st;
    } unl_regs_s;
endpackage

// File: rtl/tbt_wr_decode.sv
module tbt_wr_decode #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0483
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              key_wr,
    output logic [7:0]        key_byte
);
    always_comb begin
        key_wr   = bus_wr && (bus_addr == REG_ADDR);
        key_byte = bus_wdata;
    end
endmodule

// File: rtl/tbt_unlock.sv
module tbt_unlock
    import tbt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       armed_o,
    output logic       fire_o
);
    unl_regs_s r_d, r_q;

    always_comb begin
        r_d    = r_q;
        fire_o = 1'b0;
        unique case (r_q.st)
            UNL_IDLE: begin
                if (key_wr && key_byte == KEY_ARM)
                    r_d.st = UNL_ARMED;
            end
            UNL_ARMED: begin
                if (key_wr) begin
                    if (key_byte == KEY_FIRE) begin
                        fire_o = 1'b1;
                        r_d.st = UNL_IDLE;
                    end else if (key_byte != KEY_ARM) begin
                        r_d.st = UNL_IDLE;
                    end
                end
            end
            default: r_d.st = UNL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: UNL_IDLE};
        else        r_q <= r_d;
    end

    assign armed_o = (r_q.st == UNL_ARMED);
endmodule

// File: rtl/tbt_counter.sv
module tbt_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pulse_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cnt_regs_s;

    cnt_regs_s c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.pulse = clear_i;
        if (clear_i) c_d.cnt = '0;
        else         c_d.cnt = c_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_o   = c_q.cnt;
    assign pulse_o = c_q.pulse;
endmodule

// File: rtl/tbt_taps.sv
module tbt_taps
    import tbt_pkg::*;
#(
    parameter int                    CNT_W   = 20,
    parameter int                    NTAP    = 3,
    parameter logic [NTAP*TAP_FW-1:0] TAP_POS = {8'd15, 8'd11, 8'd7}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [NTAP-1:0]  tap_o
);
    typedef struct packed {
        logic [NTAP-1:0] tap;
    } tap_regs_s;

    tap_regs_s t_d, t_q;
    logic [NTAP-1:0] roll;
    logic            unused_cnt;

    assign unused_cnt = ^cnt_i;

    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        localparam int P = int'(TAP_POS[i*TAP_FW +: TAP_FW]);
        // low bits all ones: the next increment drops bit P to zero
        assign roll[i] = &cnt_i[P:0];
    end

    always_comb begin
        t_d     = t_q;
        t_d.tap = clear_i ? '0 : roll;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign tap_o = t_q.tap;
endmodule

// File: rtl/tbt_timebase.sv
module tbt_timebase
    import tbt_pkg::*;
#(
    parameter int                     CNT_W    = 20,
    parameter int                     ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]      REG_ADDR = 16'h0483,
    parameter int                     NTAP     = 3,
    parameter logic [NTAP*TAP_FW-1:0] TAP_POS  = {8'd15, 8'd11, 8'd7}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [CNT_W-1:0]  count_o,
    output logic [NTAP-1:0]   tap_o,
    output logic              clear_pulse_o
);
    logic       key_wr;
    logic [7:0] key_byte;
    logic       armed;
    logic       fire;

    assign bus_rdata = 8'h00;

    tbt_wr_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .key_wr    (key_wr),
        .key_byte  (key_byte)
    );

    tbt_unlock u_unl (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_byte (key_byte),
        .armed_o  (armed),
        .fire_o   (fire)
    );

    tbt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (fire),
        .cnt_o   (count_o),
        .pulse_o (clear_pulse_o)
    );

    tbt_taps #(.CNT_W(CNT_W), .NTAP(NTAP), .TAP_POS(TAP_POS)) u_taps (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (fire),
        .cnt_i   (count_o),
        .tap_o   (tap_o)
    );
endmodule

// File: rtl/tbt_timebase_chk.sv
module tbt_timebase_chk
    import tbt_pkg::*;
#(
    parameter int                     CNT_W    = 20,
    parameter int                     ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]      REG_ADDR = 16'h0483,
    parameter int                     NTAP     = 3,
    parameter logic [NTAP*TAP_FW-1:0] TAP_POS  = {8'd15, 8'd11, 8'd7}
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [CNT_W-1:0]  count_o,
    input logic [NTAP-1:0]   tap_o,
    input logic              clear_pulse_o,
    input logic              armed
);
    logic fire_wr;
    assign fire_wr = bus_wr && bus_addr == REG_ADDR && bus_wdata == KEY_FIRE;

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (clear_pulse_o || count_o == CNT_W'($past(count_o) + 1'b1)));

    a_r3_fire_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_wr && armed) |=> (clear_pulse_o && count_o == '0));

    a_r6_idle_fire_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_wr && !armed) |=> !clear_pulse_o);

    a_r9_pulse_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse_o |-> (count_o == '0 && !armed));

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse_o |=> !clear_pulse_o);

    for (genvar i = 0; i < NTAP; i++) begin : g_tapchk
        localparam int P = int'(TAP_POS[i*TAP_FW +: TAP_FW]);
        a_r10_tap_aligned: assert property (@(posedge clk) disable iff (!rst_n)
            tap_o[i] |-> (count_o[P:0] == '0 && !clear_pulse_o));
    end
endmodule

bind tbt_timebase tbt_timebase_chk #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR),
    .NTAP(NTAP), .TAP_POS(TAP_POS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .count_o       (count_o),
    .tap_o         (tap_o),
    .clear_pulse_o (clear_pulse_o),
    .armed         (armed)
);

// File: tb/sim_tbt_timebase.sv
`timescale 1ns/1ps
module sim_tbt_timebase;
    localparam int          CW   = 8;
    localparam int          NT   = 3;
    localparam logic [23:0] TPOS = {8'd6, 8'd3, 8'd1};
    localparam logic [15:0] REGA = 16'h0483;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [CW-1:0] count_o;
    logic [NT-1:0] tap_o;
    logic          clear_pulse_o;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string phase = "R2";

    // bench model
    int            m_cnt;
    bit            m_arm;
    bit            m_pulse;
    bit [NT-1:0]   m_tap;

    always #4 clk = ~clk;

    tbt_timebase #(.CNT_W(CW), .ADDR_W(16), .REG_ADDR(REGA), .NTAP(NT), .TAP_POS(TPOS)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_o(count_o),
        .tap_o(tap_o), .clear_pulse_o(clear_pulse_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_arm <= 0; m_pulse <= 0; m_tap <= '0;
        end else begin
            bit hit;
            bit fire;
            int nxt;
            hit  = bus_wr && bus_addr == REGA;
            fire = hit && m_arm && bus_wdata == 8'h5A;
            nxt  = (m_cnt + 1) % (1 << CW);
            if (hit) m_arm <= (bus_wdata == 8'hA5);
            m_pulse <= fire;
            m_cnt   <= fire ? 0 : nxt;
            for (int i = 0; i < NT; i++) begin
                int p;
                p = int'(TPOS[i*8 +: 8]);
                m_tap[i] <= !fire && ((m_cnt + 1) % (1 << (p + 1)) == 0);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({phase, " count"}, int'(count_o), m_cnt);
            chk({"R9 pulse during ", phase}, int'(clear_pulse_o), int'(m_pulse));
            chk({"R10 taps during ", phase}, int'(tap_o), int'(m_tap));
        end
    end

    task automatic report();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        report();
    end

    initial begin
        int c0;
        // R1: reset values
        repeat (3) @(negedge clk);
        chk("R1 count in reset", int'(count_o), 0);
        chk("R1 pulse in reset", int'(clear_pulse_o), 0);
        chk("R1 taps in reset", int'(tap_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count after release", int'(count_o), 1);

        // R2, R10: free run through several wraps
        phase = "R2";
        idle(600);

        // R3: basic key pair
        phase = "R3";
        wr(REGA, 8'hA5);
        wr(REGA, 8'h5A);
        chk("R3 count zero after key", int'(count_o), 0);
        chk("R9 pulse after key", int'(clear_pulse_o), 1);
        @(negedge clk);
        chk("R9 pulse drops", int'(clear_pulse_o), 0);
        chk("R3 count restarts", int'(count_o), 1);

        // R4: long idle gap, sweep of gap lengths and phases
        phase = "R4";
        for (int g = 0; g < 40; g += 3) begin
            wr(REGA, 8'hA5);
            idle(g * 7);
            wr(REGA, 8'h5A);
            chk("R4 clear after gap", int'(count_o), 0);
            idle(g);
        end

        // R5: wrong byte disarms
        phase = "R5";
        for (int v = 0; v < 256; v += 17) begin
            if (v == 8'hA5 || v == 8'h5A) continue;
            idle(5);
            wr(REGA, 8'hA5);
            wr(REGA, 8'(v));
            c0 = int'(count_o);
            wr(REGA, 8'h5A);
            chk("R5 no clear after wrong byte", int'(count_o), (c0 + 1) % 256);
            chk("R5 no pulse", int'(clear_pulse_o), 0);
        end

        // R6: fire key while disarmed
        phase = "R6";
        idle(9);
        c0 = int'(count_o);
        wr(REGA, 8'h5A);
        chk("R6 idle fire ignored", int'(count_o), (c0 + 1) % 256);

        // R9: second fire right after a clear is ignored (disarmed)
        phase = "R9";
        wr(REGA, 8'hA5);
        wr(REGA, 8'h5A);
        wr(REGA, 8'h5A);
        chk("R9 disarmed after clear", int'(count_o), 1);

        // R7: repeated arm byte
        phase = "R7";
        idle(13);
        wr(REGA, 8'hA5);
        wr(REGA, 8'hA5);
        wr(REGA, 8'hA5);
        wr(REGA, 8'h5A);
        chk("R7 clear after repeated arm", int'(count_o), 0);

        // R8: other addresses
        phase = "R8";
        idle(21);
        wr(REGA, 8'hA5);
        wr(16'h0482, 8'h33);
        wr(16'h0484, 8'h5A);
        chk("R8 other-address fire ignored", int'(clear_pulse_o), 0);
        wr(REGA, 8'h5A);
        chk("R8 still armed", int'(count_o), 0);
        idle(4);
        wr(16'h0403, 8'hA5);
        c0 = int'(count_o);
        wr(REGA, 8'h5A);
        chk("R8 other-address arm ignored", int'(count_o), (c0 + 1) % 256);

        // R10: clear placed at every phase near a tap boundary
        phase = "R10";
        for (int k = 0; k < 70; k++) begin
            wr(REGA, 8'hA5);
            idle(k % 9);
            wr(REGA, 8'h5A);
            idle(k);
        end

        // R1: reset drops an armed key
        phase = "R1";
        wr(REGA, 8'hA5);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);
        wr(REGA, 8'h5A);
        chk("R1 reset disarms", int'(clear_pulse_o), 0);
        chk("R1 count keeps running", int'(count_o), 4);

        phase = "R2";
        idle(300);
        report();
    end
endmodule